// File: doc/BRIEF.md
# Multi-mode ADC Serial Output Port

This block sends 16-bit conversion results out of a converter over one serial data pin. An upstream word source presents a new result with a one-cycle load strobe (in the full converter this happens once every 1024 master clocks). The block keeps the latest word in a holding register and drives an active-low ready flag that tells the host whether an unread word is waiting. A host starts a read by pulling the active-low select low while the ready flag is low.

A static two-bit mode input picks one of three framings. The first is a UART-style framing on an external bit clock: two bytes, each with a start bit and two stop bits. The second is a plain MSB-first shift on an external clock. The third is a plain MSB-first shift on a clock the block generates itself from the master clock. The data pin and the generated clock pin are driven only during a transfer. They are presented as value/enable pairs so that the pad ring can build the three-state buffers.

A new word blanks the ready flag for four master-clock cycles. A select falling edge inside that window is ignored. A word that arrives during a transfer does not disturb the word being shifted out, and it waits for the next access.

Top module: `adc_serial_port`

## Requirements
- R1: After reset, rdy_n is 1 and both sdata_oe and sclk_oe are 0.
- R2: After the clock edge that captures load_stb, rdy_n is 1 for exactly four cycles. It then goes to 0 when an unread word is held.
- R3: A transfer starts only on a falling edge of cs_n that is seen while rdy_n is 0 and load_stb is low. A falling edge inside the blanking window is ignored, and no transfer happens until cs_n rises and falls again.
- R4: With mode_sel = 2'b01 (or the spare code 2'b11), the word goes out MSB first, 16 bits. The first bit is driven in the cycle after the start edge. Each later bit follows a falling edge of sclk_in as sampled by clk. After the 16th falling edge, sdata_oe drops.
- R5: With mode_sel = 2'b10, sclk_o repeats every four master cycles and is high for only the fourth of them. sdata_o changes only when sclk_o falls, the word goes MSB first, and sclk_oe is 1 exactly while the transfer lasts.
- R6: With mode_sel = 2'b00, 22 bit slots go out, one per falling edge of sclk_in. The high byte frame comes first, then the low byte frame. Each frame is a 0 start bit, eight data bits LSB first, and two 1 stop bits.
- R7: When the last bit of a transfer completes and no newer word has been loaded, rdy_n goes to 1 and all outputs are released.
- R8: A word loaded during a transfer leaves the bits still being sent unchanged. rdy_n is 0 once blanking ends, and the next access sends the new word.
- R9: If cs_n rises during a transfer, the current bit runs to its end and then sdata_oe (and sclk_oe) drop. The word stays unread (rdy_n 0), and the next access sends it again from its first bit.
- R10: sclk_oe is 1 only in mode 2'b10 and only while sdata_oe is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Framing select: 00 UART bytes, 01 external clock, 10 self clock, 11 as 01 |
| load_stb | input | 1 | One-cycle strobe: new conversion word present |
| load_word | input | 16 | New conversion word |
| cs_n | input | 1 | Active-low select from the host |
| sclk_in | input | 1 | External bit clock (modes 00, 01) |
| sdata_o | output | 1 | Serial data value |
| sdata_oe | output | 1 | Drive enable for the data pin |
| sclk_o | output | 1 | Generated bit clock (mode 10) |
| sclk_oe | output | 1 | Drive enable for the clock pin |
| rdy_n | output | 1 | Active-low data-ready flag |

## Verification
The bench sweeps walking-one words and edge patterns through all three framings and compares every bit slot with a frame that it builds arithmetically from the word. A wrong bit order or a missing stop bit shows up as a slot mismatch. One test lowers the select inside the blanking window, where a design that latched or deferred that edge would start shifting with no new falling edge. Another loads a word halfway through a self-clocked transfer: a design without a separate shift copy would corrupt the remaining bits, and one that cleared readiness at the end would lose the new word. A third raises the select in the middle of a bit, where cutting the bit short or marking the word as read would show as an early release or a high ready flag.

// File: rtl/adc_sp_pkg.sv
package adc_sp_pkg;
  typedef enum logic [1:0] {
    MODE_UART    = 2'b00,
    MODE_EXTCLK  = 2'b01,
    MODE_SELFCLK = 2'b10,
    MODE_SPARE   = 2'b11
  } port_mode_e;
endpackage

// File: rtl/adc_sp_blanker.sv
module adc_sp_blanker #(
  parameter int BLANK_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic active_o
);
  localparam int CW = $clog2(BLANK_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (strobe)              cnt_d = CW'(BLANK_CYC);
    else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign active_o = (cnt_q != '0);
endmodule

// File: rtl/adc_sp_framer.sv
module adc_sp_framer #(
  parameter int WORD_W = 16,
  parameter int BYTE_W = 8,
  localparam int NBYTES = WORD_W / BYTE_W,
  localparam int SH_W   = NBYTES * (BYTE_W + 3),
  localparam int CNT_W  = $clog2(SH_W + 1)
) (
  input  logic              uart_sel,
  input  logic [WORD_W-1:0] word,
  output logic [SH_W-1:0]   vec_o,
  output logic [CNT_W-1:0]  len_o
);
  logic [SH_W-1:0] uart_vec;
  logic [SH_W-1:0] plain_vec;

  // UART framing: slot 0 leaves first; byte 0 of the frame is the high byte.
  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    localparam int BASE = b * (BYTE_W + 3);
    localparam int SRC  = WORD_W - BYTE_W * (b + 1);
    assign uart_vec[BASE] = 1'b0;
    for (genvar k = 0; k < BYTE_W; k++) begin : g_bit
      assign uart_vec[BASE+1+k] = word[SRC+k];
    end
    assign uart_vec[BASE+BYTE_W+1] = 1'b1;
    assign uart_vec[BASE+BYTE_W+2] = 1'b1;
  end

  // Plain framing: bit-reverse so the MSB sits in slot 0.
  for (genvar i = 0; i < SH_W; i++) begin : g_plain
    if (i < WORD_W) begin : g_data
      assign plain_vec[i] = word[WORD_W-1-i];
    end else begin : g_pad
      assign plain_vec[i] = 1'b0;
    end
  end

  assign vec_o = uart_sel ? uart_vec : plain_vec;
  assign len_o = uart_sel ? CNT_W'(SH_W) : CNT_W'(WORD_W);
endmodule

// File: rtl/adc_sp_shifter.sv
module adc_sp_shifter #(
  parameter int SH_W    = 22,
  parameter int CLK_DIV = 4,
  localparam int CNT_W  = $clog2(SH_W + 1),
  localparam int PH_W   = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             self_clk,
  input  logic             start,
  input  logic [SH_W-1:0]  load_vec,
  input  logic [CNT_W-1:0] load_len,
  input  logic             ext_fall,
  input  logic             stop_req,
  output logic             busy_o,
  output logic             sd_o,
  output logic             sclk_o,
  output logic             abort_o
);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(CLK_DIV - 1);

  logic [SH_W-1:0]  sh_q, sh_d;
  logic [CNT_W-1:0] left_q, left_d;
  logic [PH_W-1:0]  ph_q, ph_d;
  logic             busy_q, busy_d;
  logic             stop_q, stop_d;
  logic             adv, last, quit;

  assign adv  = busy_q & (self_clk ? (ph_q == PH_LAST) : ext_fall);
  assign last = adv & (left_q == CNT_W'(1));
  assign quit = adv & (stop_q | stop_req);

  always_comb begin
    sh_d   = sh_q;
    left_d = left_q;
    ph_d   = ph_q;
    busy_d = busy_q;
    stop_d = stop_q;
    if (start) begin
      sh_d   = load_vec;
      left_d = load_len;
      ph_d   = '0;
      busy_d = 1'b1;
      stop_d = 1'b0;
    end else if (busy_q) begin
      ph_d = (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
      if (stop_req) stop_d = 1'b1;
      if (adv) begin
        sh_d   = sh_q >> 1;
        left_d = left_q - 1'b1;
      end
      if (last || quit) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
      ph_q   <= '0;
      busy_q <= 1'b0;
      stop_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      left_q <= left_d;
      ph_q   <= ph_d;
      busy_q <= busy_d;
      stop_q <= stop_d;
    end
  end

  assign busy_o  = busy_q;
  assign sd_o    = sh_q[0];
  assign sclk_o  = busy_q & self_clk & (ph_q == PH_LAST);
  assign abort_o = quit & ~last;
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port #(
  parameter int WORD_W    = 16,
  parameter int BYTE_W    = 8,
  parameter int BLANK_CYC = 4,
  parameter int CLK_DIV   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_sel,
  input  logic              load_stb,
  input  logic [WORD_W-1:0] load_word,
  input  logic              cs_n,
  input  logic              sclk_in,
  output logic              sdata_o,
  output logic              sdata_oe,
  output logic              sclk_o,
  output logic              sclk_oe,
  output logic              rdy_n
);
  import adc_sp_pkg::*;

  localparam int NBYTES = WORD_W / BYTE_W;
  localparam int SH_W   = NBYTES * (BYTE_W + 3);
  localparam int CNT_W  = $clog2(SH_W + 1);

  port_mode_e mode;
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic [WORD_W-1:0] held_q, held_d;
  logic       pend_q, pend_d;
  logic       cs_q, sclk_q;
  logic       blank, busy, abort, start, cs_fall, ext_fall, self_clk;
  logic [SH_W-1:0]  vec;
  logic [CNT_W-1:0] len;

  assign mode = port_mode_e'(mode_sel);

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b0;
      held_q <= '0;
      pend_q <= 1'b0;
    end else begin
      cs_q   <= cs_n;
      sclk_q <= sclk_in;
      held_q <= held_d;
      pend_q <= pend_d;
    end
  end

  assign self_clk = (mode == MODE_SELFCLK);
  assign cs_fall  = cs_q & ~cs_n;
  assign ext_fall = sclk_q & ~sclk_in;
  assign start    = cs_fall & ~load_stb & ~blank & pend_q & ~busy;

  always_comb begin
    held_d = held_q;
    pend_d = pend_q;
    if (load_stb) begin
      held_d = load_word;
      pend_d = 1'b1;
    end else if (start) begin
      pend_d = 1'b0;
    end
    if (abort) pend_d = 1'b1;
  end

  adc_sp_blanker #(.BLANK_CYC(BLANK_CYC)) u_blank (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .strobe   (load_stb),
    .active_o (blank)
  );

  adc_sp_framer #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_frame (
    .uart_sel (mode == MODE_UART),
    .word     (held_q),
    .vec_o    (vec),
    .len_o    (len)
  );

  adc_sp_shifter #(.SH_W(SH_W), .CLK_DIV(CLK_DIV)) u_shift (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .self_clk (self_clk),
    .start    (start),
    .load_vec (vec),
    .load_len (len),
    .ext_fall (ext_fall),
    .stop_req (cs_n),
    .busy_o   (busy),
    .sd_o     (sdata_o),
    .sclk_o   (sclk_o),
    .abort_o  (abort)
  );

  assign sdata_oe = busy;
  assign sclk_oe  = busy & self_clk;
  assign rdy_n    = blank | ~(pend_q | busy);
endmodule

// File: rtl/adc_sp_checker.sv
module adc_sp_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_sel,
  input logic       load_stb,
  input logic       cs_n,
  input logic       sclk_in,
  input logic       sdata_o,
  input logic       sdata_oe,
  input logic       sclk_o,
  input logic       sclk_oe,
  input logic       rdy_n
);
  AST_LOAD_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> rdy_n); // R2

  AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdata_oe) |-> ($past(!rdy_n) && !$past(cs_n) && !$past(load_stb))); // R3

  AST_EXT_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel[0] && sdata_oe && $past(sdata_oe) && !($past(sclk_in, 2) && !$past(sclk_in)))
      |-> $stable(sdata_o)); // R4

  AST_SELF_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_o |=> !sclk_o); // R5

  AST_SELF_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b10 && sdata_oe && $past(sdata_oe) && !$past(sclk_o))
      |-> $stable(sdata_o)); // R5

  AST_SCLK_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_oe |-> (mode_sel == 2'b10 && sdata_oe)); // R10
endmodule

bind adc_serial_port adc_sp_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode_sel (mode_sel),
  .load_stb (load_stb),
  .cs_n     (cs_n),
  .sclk_in  (sclk_in),
  .sdata_o  (sdata_o),
  .sdata_oe (sdata_oe),
  .sclk_o   (sclk_o),
  .sclk_oe  (sclk_oe),
  .rdy_n    (rdy_n)
);

// File: tb/tb_adc_serial_port.sv
module tb_adc_serial_port;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n, load_stb, cs_n, sclk_in;
  logic [1:0]  mode_sel;
  logic [15:0] load_word;
  logic        sdata_o, sdata_oe, sclk_o, sclk_oe, rdy_n;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_serial_port dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .load_stb(load_stb),
    .load_word(load_word), .cs_n(cs_n), .sclk_in(sclk_in),
    .sdata_o(sdata_o), .sdata_oe(sdata_oe), .sclk_o(sclk_o),
    .sclk_oe(sclk_oe), .rdy_n(rdy_n)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  function automatic logic [21:0] uart_frame(input logic [15:0] w);
    logic [21:0] f;
    f[0] = 1'b0; f[9] = 1'b1; f[10] = 1'b1;
    f[11] = 1'b0; f[20] = 1'b1; f[21] = 1'b1;
    for (int k = 0; k < 8; k++) begin
      f[1+k]  = w[8+k];
      f[12+k] = w[k];
    end
    return f;
  endfunction

  function automatic logic [21:0] plain_frame(input logic [15:0] w);
    logic [21:0] f = '0;
    for (int i = 0; i < 16; i++) f[i] = w[15-i];
    return f;
  endfunction

  // R2: four blanked samples, then ready.
  task automatic load(input logic [15:0] w);
    @(negedge clk); load_stb = 1'b1; load_word = w;
    @(negedge clk); load_stb = 1'b0;
    for (int k = 0; k < 4; k++) begin
      chk("R2 rdy_n blanked", rdy_n, 1);
      @(negedge clk);
    end
    chk("R2 rdy_n ready after blanking", rdy_n, 0);
  endtask

  // Externally clocked transfer (R4 plain, R6 UART), then release.
  task automatic xfer_ext(input logic [21:0] exp, input int len, input string tag,
                          input logic exp_rdy);
    @(negedge clk); cs_n = 1'b0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      chk({tag, " oe"}, sdata_oe, 1);
      chk({tag, " slot"}, {i[15:0], 15'd0, sdata_o}, {i[15:0], 15'd0, exp[i]});
      sclk_in = 1'b1;
      @(negedge clk); sclk_in = 1'b0;
    end
    @(negedge clk);
    chk("R7 oe released", sdata_oe, 0);
    chk("R7 rdy_n after end", rdy_n, exp_rdy);
    cs_n = 1'b1;
    @(negedge clk);
  endtask

  // Self-clocked transfer with optional mid-word load (R8) or select raise (R9).
  task automatic xfer_self(input logic [15:0] w, input int ld_at, input logic [15:0] ld_w,
                           input int up_at, input logic exp_rdy);
    int last_c;
    last_c = (up_at >= 0) ? 4 * (up_at / 4 + 1) : 64;
    @(negedge clk); cs_n = 1'b0;
    for (int c = 0; c < last_c; c++) begin
      @(negedge clk);
      chk("R5 sclk_oe", sclk_oe, 1);
      chk("R5 sclk_o", sclk_o, (c % 4) == 3);
      chk("R5 sdata", {c[15:0], 15'd0, sdata_o}, {c[15:0], 15'd0, w[15 - c/4]});
      if (ld_at >= 0 && c == ld_at + 1) chk("R8 blank mid transfer", rdy_n, 1);
      if (ld_at >= 0 && c == ld_at + 5) chk("R8 ready after blank", rdy_n, 0);
      if (c == ld_at)     begin load_stb = 1'b1; load_word = ld_w; end
      if (c == ld_at + 1) load_stb = 1'b0;
      if (c == up_at)     cs_n = 1'b1;
    end
    @(negedge clk);
    chk((up_at >= 0) ? "R9 oe off after bit" : "R7 oe released", sdata_oe, 0);
    chk("R5 sclk_oe off", sclk_oe, 0);
    chk((up_at >= 0) ? "R9 word still unread" : "R7 rdy_n after end", rdy_n, exp_rdy);
    cs_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    logic [15:0] pats [6];
    pats = '{16'h0000, 16'hFFFF, 16'h8001, 16'hA5C3, 16'h1234, 16'h7FFE};
    rst_n = 1'b0; load_stb = 1'b0; load_word = '0; cs_n = 1'b1;
    sclk_in = 1'b0; mode_sel = 2'b01;
    repeat (3) @(negedge clk);
    chk("R1 rdy_n", rdy_n, 1);
    chk("R1 sdata_oe", sdata_oe, 0);
    chk("R1 sclk_oe", sclk_oe, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 rdy_n after release", rdy_n, 1);

    // External clock mode: walking ones and patterns.
    for (int b = 0; b < 16; b++) begin
      load(16'h1 << b);
      xfer_ext(plain_frame(16'h1 << b), 16, "R4", 1'b1);
    end
    foreach (pats[i]) begin
      load(pats[i]);
      xfer_ext(plain_frame(pats[i]), 16, "R4", 1'b1);
    end
    // Spare code acts as external clock mode.
    mode_sel = 2'b11;
    load(16'hC3A5);
    xfer_ext(plain_frame(16'hC3A5), 16, "R4 spare", 1'b1);
    mode_sel = 2'b01;

    // R3: select falls inside the blanking window and is ignored.
    @(negedge clk); load_stb = 1'b1; load_word = 16'h5A0F;
    @(negedge clk); load_stb = 1'b0;
    @(negedge clk); cs_n = 1'b0;
    repeat (10) @(negedge clk);
    chk("R3 ignored select no drive", sdata_oe, 0);
    chk("R3 word waits", rdy_n, 0);
    cs_n = 1'b1;
    @(negedge clk);
    xfer_ext(plain_frame(16'h5A0F), 16, "R3 later access", 1'b1);

    // UART mode.
    mode_sel = 2'b00;
    for (int b = 0; b < 16; b += 3) begin
      load(16'h1 << b);
      xfer_ext(uart_frame(16'h1 << b), 22, "R6", 1'b1);
    end
    foreach (pats[i]) begin
      load(pats[i]);
      xfer_ext(uart_frame(pats[i]), 22, "R6", 1'b1);
    end

    // Self clock mode.
    mode_sel = 2'b10;
    foreach (pats[i]) begin
      load(pats[i]);
      xfer_self(pats[i], -1, 16'h0, -1, 1'b1);
    end
    // R8: new word mid transfer.
    load(16'hBEEF);
    xfer_self(16'hBEEF, 20, 16'h0F0F, -1, 1'b0);
    xfer_self(16'h0F0F, -1, 16'h0, -1, 1'b1);
    // R9: select raised in bit 1, then a full re-read.
    load(16'hC0DE);
    xfer_self(16'hC0DE, -1, 16'h0, 5, 1'b0);
    xfer_self(16'hC0DE, -1, 16'h0, -1, 1'b1);

    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end
endmodule